// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns a base register value and an offset into the byte address of a load or store. It is also told which register the base came from. A 3-bit mode selects how the two combine. Plain indirect uses the base alone. The offset forms add the offset to the base or subtract it, and leave the base unchanged. The pre-modify forms compute the new base and access memory at that new value. The post-modify forms access memory at the old base and then hand the new base back for write-back.

The offset can come from four sources: a short 5-bit unsigned constant, a full-width register, a long 15-bit unsigned constant, or an implied value of one when the instruction gives no offset. The long constant is accepted only in the positive-offset mode, and only when the base is one of two designated registers: the data-page pointer and the stack pointer. Every offset is scaled by the access size before use. A request the block cannot form is flagged as an error and produces neither an access nor a write-back. Results appear one clock after the request.

Top module: `ldst_addr_gen`

## Requirements
- R1: Mode 0 (plain indirect): memAddr equals baseVal, wbEn stays low, and the offset inputs have no effect on memAddr.
- R2: Modes 1 (positive) and 2 (negative): memAddr equals baseVal plus (mode 1) or minus (mode 2) the scaled offset, modulo 2^ADDR_W, and wbEn stays low.
- R3: Modes 3 (pre-increment) and 4 (pre-decrement): wbVal equals baseVal plus (mode 3) or minus (mode 4) the scaled offset, memAddr equals wbVal, and wbEn is high.
- R4: Modes 5 (post-increment) and 6 (post-decrement): memAddr equals the old baseVal, wbVal equals baseVal plus (mode 5) or minus (mode 6) the scaled offset, and wbEn is high.
- R5: offSrc 0 takes the offset from offConst[4:0], zero-extended, and ignores offConst[14:5]. offSrc 1 takes the offset from the full offReg value.
- R6: offSrc 2 takes the offset from offConst[14:0], zero-extended. It is legal only with mode 1 and baseIdx equal to DP_REG (30) or SP_REG (31). Any other use of offSrc 2 raises reqErr and holds addrValid and wbEn low.
- R7: offSrc 3 (no offset given) uses an offset of 1 in modes 3 to 6. In modes 0 to 2 it raises reqErr.
- R8: The offset is shifted left by accSize before use: 0 for a byte, 1 for a halfword, 2 for a word. accSize 3 raises reqErr.
- R9: Outputs follow a request by exactly one clock. On a legal request memSize echoes accSize and wbIdx echoes baseIdx. Mode 7 raises reqErr. A cycle with reqValid low leaves addrValid, wbEn and reqErr low in the following cycle.
- R10: While rstN is low, addrValid, wbEn, reqErr, memAddr and wbVal are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| modeSel | input | 3 | Addressing mode, 0 to 7 |
| offSrc | input | 2 | Offset source: 0 short constant, 1 register, 2 long constant, 3 implied one |
| accSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| baseIdx | input | REG_IDX_W (5) | Index of the base register |
| baseVal | input | ADDR_W (32) | Base register value |
| offReg | input | ADDR_W (32) | Offset register value |
| offConst | input | LONG_W (15) | Constant offset field |
| addrValid | output | 1 | memAddr holds a legal access |
| memAddr | output | ADDR_W (32) | Effective byte address |
| memSize | output | 2 | Access size code of the access |
| wbEn | output | 1 | Base write-back enable |
| wbIdx | output | REG_IDX_W (5) | Register to write back |
| wbVal | output | ADDR_W (32) | Updated base value |
| reqErr | output | 1 | Request rejected as illegal |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 5-bit register indices, and registers 30 and 31 as the two bases that allow the long offset. These values let the bench drive the largest long offset, 32767. Scaled to a word, that offset is 131068. The bench also uses bases near zero and near 2^32-1, so both the add and the subtract paths wrap around the address space. Every illegal combination also lies within reach: the long offset against each of the other 30 base registers and against the other modes.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

  typedef enum logic [2:0] {
    MODE_PLAIN   = 3'd0,
    MODE_POS     = 3'd1,
    MODE_NEG     = 3'd2,
    MODE_PREINC  = 3'd3,
    MODE_PREDEC  = 3'd4,
    MODE_POSTINC = 3'd5,
    MODE_POSTDEC = 3'd6,
    MODE_BAD     = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    SRC_SHORT = 2'd0,
    SRC_REG   = 2'd1,
    SRC_LONG  = 2'd2,
    SRC_ONE   = 2'd3
  } agu_src_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } agu_size_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic fire;       // legal request: capture results
    logic reject;     // illegal request
    logic subtract;   // base minus offset
    logic zeroOff;    // offset forced to zero
    logic useSum;     // address from modified base
    logic writeBack;  // base update requested
  } agu_ctrl_t;

endpackage

// File: rtl/ldst_agu_ctrl.sv
module ldst_agu_ctrl
  import ldst_agu_pkg::*;
#(
  parameter int REG_IDX_W = 5,
  parameter int DP_REG    = 30,
  parameter int SP_REG    = 31
) (
  input  logic                 reqValid,
  input  logic [2:0]           modeSel,
  input  logic [1:0]           offSrc,
  input  logic [1:0]           accSize,
  input  logic [REG_IDX_W-1:0] baseIdx,
  output agu_ctrl_t            strobes
);

  localparam logic [REG_IDX_W-1:0] DpIdx = REG_IDX_W'(DP_REG);
  localparam logic [REG_IDX_W-1:0] SpIdx = REG_IDX_W'(SP_REG);

  agu_mode_e mode;
  agu_src_e  src;
  logic      longBaseOk;
  logic      illegal;
  logic      modifyForm;

  always_comb begin
    mode       = agu_mode_e'(modeSel);
    src        = agu_src_e'(offSrc);
    longBaseOk = (baseIdx == DpIdx) || (baseIdx == SpIdx);
    modifyForm = (mode == MODE_PREINC) || (mode == MODE_PREDEC) ||
                 (mode == MODE_POSTINC) || (mode == MODE_POSTDEC);

    illegal = 1'b0;
    if (mode == MODE_BAD) illegal = 1'b1;
    if (agu_size_e'(accSize) == SZ_BAD) illegal = 1'b1;
    if (src == SRC_LONG && !(mode == MODE_POS && longBaseOk)) illegal = 1'b1;
    if (src == SRC_ONE && !modifyForm) illegal = 1'b1;

    strobes.fire      = reqValid && !illegal;
    strobes.reject    = reqValid && illegal;
    strobes.subtract  = (mode == MODE_NEG) || (mode == MODE_PREDEC) ||
                        (mode == MODE_POSTDEC);
    strobes.zeroOff   = (mode == MODE_PLAIN);
    strobes.useSum    = !((mode == MODE_POSTINC) || (mode == MODE_POSTDEC));
    strobes.writeBack = modifyForm;
  end

endmodule

// File: rtl/ldst_agu_dp.sv
module ldst_agu_dp
  import ldst_agu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int SHORT_W   = 5,
  parameter int LONG_W    = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  agu_ctrl_t            strobes,
  input  logic [1:0]           offSrc,
  input  logic [1:0]           accSize,
  input  logic [REG_IDX_W-1:0] baseIdx,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [ADDR_W-1:0]    offReg,
  input  logic [LONG_W-1:0]    offConst,
  output logic                 addrValid,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [1:0]           memSize,
  output logic                 wbEn,
  output logic [REG_IDX_W-1:0] wbIdx,
  output logic [ADDR_W-1:0]    wbVal,
  output logic                 reqErr
);

  logic [ADDR_W-1:0] offRaw;
  logic [ADDR_W-1:0] offScaled;
  logic [ADDR_W-1:0] newBase;

  always_comb begin
    unique case (agu_src_e'(offSrc))
      SRC_SHORT: offRaw = ADDR_W'(offConst[SHORT_W-1:0]);
      SRC_REG:   offRaw = offReg;
      SRC_LONG:  offRaw = ADDR_W'(offConst);
      default:   offRaw = ADDR_W'(1);
    endcase
    offScaled = strobes.zeroOff ? '0 : (offRaw << accSize);
    newBase   = strobes.subtract ? (baseVal - offScaled) : (baseVal + offScaled);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      wbEn      <= 1'b0;
      reqErr    <= 1'b0;
      memAddr   <= '0;
      wbVal     <= '0;
      memSize   <= '0;
      wbIdx     <= '0;
    end else begin
      addrValid <= strobes.fire;
      wbEn      <= strobes.fire && strobes.writeBack;
      reqErr    <= strobes.reject;
      if (strobes.fire) begin
        memAddr <= strobes.useSum ? newBase : baseVal;
        wbVal   <= newBase;
        memSize <= accSize;
        wbIdx   <= baseIdx;
      end
    end
  end

endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_agu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int SHORT_W   = 5,
  parameter int LONG_W    = 15,
  parameter int DP_REG    = 30,
  parameter int SP_REG    = 31
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [2:0]           modeSel,
  input  logic [1:0]           offSrc,
  input  logic [1:0]           accSize,
  input  logic [REG_IDX_W-1:0] baseIdx,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [ADDR_W-1:0]    offReg,
  input  logic [LONG_W-1:0]    offConst,
  output logic                 addrValid,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [1:0]           memSize,
  output logic                 wbEn,
  output logic [REG_IDX_W-1:0] wbIdx,
  output logic [ADDR_W-1:0]    wbVal,
  output logic                 reqErr
);

  agu_ctrl_t strobes;

  ldst_agu_ctrl #(
    .REG_IDX_W(REG_IDX_W),
    .DP_REG   (DP_REG),
    .SP_REG   (SP_REG)
  ) u_ctrl (
    .reqValid(reqValid),
    .modeSel (modeSel),
    .offSrc  (offSrc),
    .accSize (accSize),
    .baseIdx (baseIdx),
    .strobes (strobes)
  );

  ldst_agu_dp #(
    .ADDR_W   (ADDR_W),
    .REG_IDX_W(REG_IDX_W),
    .SHORT_W  (SHORT_W),
    .LONG_W   (LONG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .offSrc   (offSrc),
    .accSize  (accSize),
    .baseIdx  (baseIdx),
    .baseVal  (baseVal),
    .offReg   (offReg),
    .offConst (offConst),
    .addrValid(addrValid),
    .memAddr  (memAddr),
    .memSize  (memSize),
    .wbEn     (wbEn),
    .wbIdx    (wbIdx),
    .wbVal    (wbVal),
    .reqErr   (reqErr)
  );

endmodule

// File: rtl/ldst_addr_gen_chk.sv
module ldst_addr_gen_chk #(
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int LONG_W    = 15,
  parameter int DP_REG    = 30,
  parameter int SP_REG    = 31
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [2:0]           modeSel,
  input logic [1:0]           offSrc,
  input logic [REG_IDX_W-1:0] baseIdx,
  input logic [ADDR_W-1:0]    baseVal,
  input logic                 addrValid,
  input logic [ADDR_W-1:0]    memAddr,
  input logic                 wbEn,
  input logic [ADDR_W-1:0]    wbVal,
  input logic                 reqErr
);

  logic longBase;
  assign longBase = (baseIdx == REG_IDX_W'(DP_REG)) || (baseIdx == REG_IDX_W'(SP_REG));

  // R1: plain indirect addresses at the base, no write-back
  assert_plain_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && modeSel == 3'd0) |=> (reqErr || (memAddr == $past(baseVal) && !wbEn)));

  // R2: offset forms never write back
  assert_offset_no_wb_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (modeSel == 3'd1 || modeSel == 3'd2)) |=> !wbEn);

  // R3: pre-modify accesses the updated base
  assert_pre_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (modeSel == 3'd3 || modeSel == 3'd4)) |=> (reqErr || (wbEn && memAddr == wbVal)));

  // R4: post-modify accesses the old base
  assert_post_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (modeSel == 3'd5 || modeSel == 3'd6)) |=> (reqErr || (wbEn && memAddr == $past(baseVal))));

  // R6: long offset off the designated bases is rejected
  assert_long_base_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && offSrc == 2'd2 && !longBase) |=> (reqErr && !addrValid && !wbEn));

  // R9: idle cycle yields no result flags
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!addrValid && !wbEn && !reqErr));

  // R9: error and access are exclusive, write-back implies access
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(reqErr && addrValid) && (!wbEn || addrValid));

endmodule

bind ldst_addr_gen ldst_addr_gen_chk #(
  .ADDR_W   (ADDR_W),
  .REG_IDX_W(REG_IDX_W),
  .LONG_W   (LONG_W),
  .DP_REG   (DP_REG),
  .SP_REG   (SP_REG)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .modeSel  (modeSel),
  .offSrc   (offSrc),
  .baseIdx  (baseIdx),
  .baseVal  (baseVal),
  .addrValid(addrValid),
  .memAddr  (memAddr),
  .wbEn     (wbEn),
  .wbVal    (wbVal),
  .reqErr   (reqErr)
);

// File: tb/ldst_addr_gen_bench.sv
module ldst_addr_gen_bench;

  localparam int AW = 32;
  localparam int IW = 5;
  localparam int LW = 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    modeSel = '0;
  logic [1:0]    offSrc = '0;
  logic [1:0]    accSize = '0;
  logic [IW-1:0] baseIdx = '0;
  logic [AW-1:0] baseVal = '0;
  logic [AW-1:0] offReg = '0;
  logic [LW-1:0] offConst = '0;
  logic          addrValid, wbEn, reqErr;
  logic [AW-1:0] memAddr, wbVal;
  logic [1:0]    memSize;
  logic [IW-1:0] wbIdx;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  ldst_addr_gen u_ldst_addr_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeSel(modeSel),
    .offSrc(offSrc), .accSize(accSize), .baseIdx(baseIdx), .baseVal(baseVal),
    .offReg(offReg), .offConst(offConst), .addrValid(addrValid),
    .memAddr(memAddr), .memSize(memSize), .wbEn(wbEn), .wbIdx(wbIdx),
    .wbVal(wbVal), .reqErr(reqErr)
  );

  task automatic check(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [2:0] m, input logic [1:0] s,
                                   input logic [1:0] z, input logic err);
    if (err) begin
      if (m == 3'd7) return "R9";
      if (z == 2'd3) return "R8";
      if (s == 2'd2) return "R6";
      return "R7";
    end
    case (m)
      3'd0: return "R1";
      3'd1, 3'd2: return "R2";
      3'd3, 3'd4: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Drive one request, then compare the outputs one clock later
  task automatic runReq(input logic [2:0] m, input logic [1:0] s, input logic [1:0] z,
                        input logic [IW-1:0] idx, input logic [AW-1:0] b,
                        input logic [AW-1:0] r, input logic [LW-1:0] c);
    logic          eErr, eWb;
    logic [AW-1:0] off, sum, eAddr;
    string         tag;
    eErr = (m == 3'd7) || (z == 2'd3) ||
           (s == 2'd2 && !(m == 3'd1 && (idx == 5'd30 || idx == 5'd31))) ||
           (s == 2'd3 && m < 3'd3);
    case (s)
      2'd0: off = AW'(c[4:0]);
      2'd1: off = r;
      2'd2: off = AW'(c);
      default: off = 1;
    endcase
    if (m == 3'd0) off = '0;
    off   = off << z;
    sum   = (m == 3'd2 || m == 3'd4 || m == 3'd6) ? b - off : b + off;
    eAddr = (m == 3'd5 || m == 3'd6) ? b : sum;
    eWb   = !eErr && (m >= 3'd3) && (m <= 3'd6);
    tag   = tagFor(m, s, z, eErr);

    @(negedge clk);
    reqValid = 1'b1; modeSel = m; offSrc = s; accSize = z;
    baseIdx = idx; baseVal = b; offReg = r; offConst = c;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, "reqErr", AW'(reqErr), AW'(eErr));
    check(tag, "addrValid", AW'(addrValid), AW'(!eErr));
    check(tag, "wbEn", AW'(wbEn), AW'(eWb));
    if (!eErr) begin
      check(tag, "memAddr", memAddr, eAddr);
      check("R9", "memSize", AW'(memSize), AW'(z));
      check("R9", "wbIdx", AW'(wbIdx), AW'(idx));
      if (eWb) check(tag, "wbVal", wbVal, sum);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "addrValid", AW'(addrValid), '0);
    check("R10", "wbEn", AW'(wbEn), '0);
    check("R10", "reqErr", AW'(reqErr), '0);
    check("R10", "memAddr", memAddr, '0);
    check("R10", "wbVal", wbVal, '0);
    rstN = 1'b1;

    // R1: plain ignores offsets
    runReq(3'd0, 2'd1, 2'd2, 5'd3, 32'h1000_0040, 32'hFFFF_FFFF, 15'h7FFF);
    // R2: boundary short offsets, wrap on subtract
    runReq(3'd1, 2'd0, 2'd0, 5'd4, 32'h0000_0100, '0, 15'd0);
    runReq(3'd2, 2'd0, 2'd2, 5'd4, 32'h0000_0010, '0, 15'd31);
    // R5: upper constant bits ignored for short source
    runReq(3'd1, 2'd0, 2'd0, 5'd5, 32'h0000_2000, '0, 15'h7FE1);
    // R3 / R4: pre and post forms, wrap on add
    runReq(3'd3, 2'd1, 2'd1, 5'd6, 32'hFFFF_FFFE, 32'd3, '0);
    runReq(3'd4, 2'd0, 2'd2, 5'd6, 32'h0000_0080, '0, 15'd31);
    runReq(3'd5, 2'd1, 2'd0, 5'd7, 32'h8000_0000, 32'h7FFF_FFFF, '0);
    runReq(3'd6, 2'd0, 2'd1, 5'd7, 32'h0000_0000, '0, 15'd1);
    // R6: long offset legal on both designated bases, illegal elsewhere
    runReq(3'd1, 2'd2, 2'd2, 5'd31, 32'h0001_0000, '0, 15'd32767);
    runReq(3'd1, 2'd2, 2'd0, 5'd30, 32'hFFFF_0000, '0, 15'd32767);
    runReq(3'd1, 2'd2, 2'd2, 5'd14, 32'h0001_0000, '0, 15'd100);
    runReq(3'd3, 2'd2, 2'd2, 5'd31, 32'h0001_0000, '0, 15'd100);
    // R7: implied one
    runReq(3'd5, 2'd3, 2'd2, 5'd9, 32'h0000_1000, '0, 15'd77);
    runReq(3'd4, 2'd3, 2'd1, 5'd9, 32'h0000_1000, '0, 15'd77);
    runReq(3'd1, 2'd3, 2'd0, 5'd9, 32'h0000_1000, '0, 15'd77);
    // R8: size scaling and bad size
    runReq(3'd1, 2'd1, 2'd1, 5'd2, 32'h0, 32'h4000_0001, '0);
    runReq(3'd1, 2'd0, 2'd3, 5'd2, 32'h0, '0, 15'd1);
    // R9: bad mode, idle cycle
    runReq(3'd7, 2'd0, 2'd0, 5'd2, 32'h0, '0, 15'd1);
    @(negedge clk);
    check("R9", "idle addrValid", AW'(addrValid), '0);
    check("R9", "idle reqErr", AW'(reqErr), '0);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0]    m;
      logic [1:0]    s, z;
      logic [IW-1:0] idx;
      logic [AW-1:0] b;
      logic [LW-1:0] c;
      m   = 3'($urandom_range(0, 7));
      s   = 2'($urandom_range(0, 3));
      z   = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      idx = ($urandom_range(0, 2) == 0) ? IW'($urandom_range(30, 31)) : IW'($urandom);
      case ($urandom_range(0, 5))
        0: c = 15'd0;
        1: c = 15'd31;
        2: c = 15'd32767;
        default: c = LW'($urandom);
      endcase
      case ($urandom_range(0, 4))
        0: b = 32'h0000_0000;
        1: b = 32'hFFFF_FFFF;
        default: b = $urandom;
      endcase
      runReq(m, s, z, idx, b, $urandom, c);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule